// File: doc/BRIEF.md
# JTAG Status Readback Sequencer

This block is the host side of a JTAG link. It reads the 32-bit status register of a configurable device through that device's test access port. It makes TCK from the system clock and drives TMS and TDI. On each rising TCK edge it samples TDO. A single start pulse runs a fixed script of 240 TCK periods, described below.

1. The script walks the target's TAP to Test-Logic-Reset and then to Run-Test/Idle.
2. It loads the configuration-input instruction and streams five 32-bit configuration packets: a sync word, a no-op, a status-read header and two flush no-ops.
3. It loads the configuration-output instruction and clocks 32 status bits out of TDO.
4. It returns the TAP to Test-Logic-Reset.

Instruction shifts go least significant bit first. Packet shifts go most significant bit first. The last bit of every shift goes out on the TCK period whose TMS is high, which leaves the shift state.

The host raises `start` for one cycle. `busy` stays high while the script runs. At the end, `done` pulses for one cycle and `status` takes the new word. `status` then holds that value until the next run completes.

Top module: `cfg_stat_reader`

## Requirements
- R1: After reset: tck=0, tms=1, tdi=0, busy=0, done=0 and status=0.
- R2: TCK rises CLK_DIV/2 system cycles after it falls and falls CLK_DIV-CLK_DIV/2 cycles after it rises (CLK_DIV at least 2). TCK stays low while idle. TMS and TDI change only at the clock edge where TCK falls.
- R3: The per-period TMS script works as follows. It opens with 5 periods high, then 1 low, 2 high and 2 low to reach Shift-IR. After each instruction, the pattern is 1,1,0,0. After the packet stream, it is 1,1,1,0,0. The script closes with 5 periods high, which leaves the target in Test-Logic-Reset.
- R4: Each instruction is IR_LEN (10) bits, sent bit 0 first. The last bit goes with TMS high and all earlier bits with TMS low. The first instruction is IN_CODE (default 10'h3C5) and the second is OUT_CODE (default 10'h3C4).
- R5: The packet stream is 160 bits: 32'hAA995566, 32'h20000000, 32'h2800E001, 32'h20000000, 32'h20000000, in that order. Each word is sent bit 31 first. TMS is high only on bit 160.
- R6: The readout takes 32 periods. TDO is sampled at each rising TCK, and the first bit received becomes status bit 0. TMS is high only on the 32nd period.
- R7: `status` changes only in the cycle `done` is high. It keeps its value, including through a following run, until that run completes.
- R8: `busy` rises the cycle after an accepted start. It stays high for 1+240*CLK_DIV cycles.
- R9: `done` is high for exactly one cycle, the first cycle with busy low after a run.
- R10: TDI is 0 during every TAP navigation period, during the readout and while idle.
- R11: A start while busy is high has no effect. A start in the cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a readback run when idle |
| tdo | input | 1 | Serial data from target |
| tck | output | 1 | Test clock to target |
| tms | output | 1 | Test mode select to target |
| tdi | output | 1 | Serial data to target |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | STAT_W | Captured status word |

## Verification
The completion of one run and the start of the next can fall in the same cycle, because `done` is high exactly when `busy` has dropped. The bench raises `start` in the cycle it sees `done`. It then judges the second run by a full busy length of 1+240*CLK_DIV cycles and a complete, correct TCK script. It also checks that `status` keeps the first word until the second run ends. A separate run holds `start` high for three cycles in mid-run and checks that the run length stays the same and that only one `done` follows.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int PKT_W    = 32;
    localparam int PKT_N    = 5;
    localparam int PKT_BITS = PKT_W * PKT_N;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_A,
        S_RTI,
        S_SELIR,
        S_CAPIR,
        S_SHIR,
        S_TODR,
        S_WRDR,
        S_TOIR,
        S_RDDR,
        S_RST_B,
        S_DONE
    } seg_t;

    function automatic logic [PKT_W-1:0] pkt_word(input int idx);
        case (idx)
            0:       return 32'hAA99_5566;
            2:       return 32'h2800_E001;
            default: return 32'h2000_0000;
        endcase
    endfunction

endpackage

// File: rtl/csr_tck_div.sv
module csr_tck_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fall_now,
    output logic rise_now,
    output logic tck
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             tck_d, tck_q;

    always_comb begin
        fall_now = run && (int'(cnt_q) == 0);
        rise_now = run && (int'(cnt_q) == HALF);
        cnt_d    = cnt_q;
        tck_d    = tck_q;
        if (!run) begin
            cnt_d = '0;
            tck_d = 1'b0;
        end else begin
            if (int'(cnt_q) == CLK_DIV - 1) cnt_d = '0;
            else                            cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
            if (fall_now)      tck_d = 1'b0;
            else if (rise_now) tck_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            tck_q <= tck_d;
        end
    end

    assign tck = tck_q;

endmodule

// File: rtl/csr_script.sv
module csr_script
    import csr_pkg::*;
#(
    parameter int              IR_LEN   = 10,
    parameter logic [IR_LEN-1:0] IN_CODE  = 10'h3C5,
    parameter logic [IR_LEN-1:0] OUT_CODE = 10'h3C4,
    parameter int              STAT_W   = 32,
    parameter int              BIT_W    = 8
) (
    input  seg_t             seg,
    input  logic [BIT_W-1:0] bitn,
    input  logic             pass,
    output logic             tms,
    output logic             tdi,
    output logic             last,
    output logic             capture
);
    int                idx;
    int                len;
    int                pos;
    logic [IR_LEN-1:0] code;
    logic [PKT_W-1:0]  word;

    always_comb begin
        idx     = int'(bitn);
        code    = pass ? OUT_CODE : IN_CODE;
        word    = pkt_word(idx / PKT_W);
        pos     = PKT_W - 1 - (idx % PKT_W);
        tms     = 1'b0;
        tdi     = 1'b0;
        capture = 1'b0;
        case (seg)
            S_RST_A, S_RST_B: len = 5;
            S_RTI:            len = 1;
            S_SELIR, S_CAPIR: len = 2;
            S_SHIR:           len = IR_LEN;
            S_TODR:           len = 4;
            S_WRDR:           len = PKT_BITS;
            S_TOIR:           len = 3;
            S_RDDR:           len = STAT_W;
            default:          len = 1;
        endcase
        last = (idx == len - 1);
        case (seg)
            S_RST_A, S_RST_B, S_SELIR, S_TOIR: tms = 1'b1;
            S_TODR:  tms = (idx < 2);
            S_SHIR: begin
                tms = last;
                for (int i = 0; i < IR_LEN; i++)
                    if (idx == i) tdi = code[i];
            end
            S_WRDR: begin
                tms = last;
                for (int k = 0; k < PKT_W; k++)
                    if (pos == k) tdi = word[k];
            end
            S_RDDR: begin
                tms     = last;
                capture = 1'b1;
            end
            default: tms = 1'b0;
        endcase
    end

endmodule

// File: rtl/csr_shift_cap.sv
module csr_shift_cap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clear)      word_d = '0;
        else if (shift) word_d = {din, word_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

endmodule

// File: rtl/cfg_stat_reader.sv
module cfg_stat_reader
    import csr_pkg::*;
#(
    parameter int                CLK_DIV  = 4,
    parameter int                IR_LEN   = 10,
    parameter logic [IR_LEN-1:0] IN_CODE  = 10'h3C5,
    parameter logic [IR_LEN-1:0] OUT_CODE = 10'h3C4,
    parameter int                STAT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] status
);
    localparam int MAX_A  = (PKT_BITS > IR_LEN) ? PKT_BITS : IR_LEN;
    localparam int MAXLEN = (MAX_A > STAT_W) ? MAX_A : STAT_W;
    localparam int BIT_W  = $clog2(MAXLEN + 1);

    typedef struct packed {
        seg_t              seg;
        logic [BIT_W-1:0]  bitn;
        logic              pass;
        logic              busy;
        logic              done;
        logic              tms;
        logic              tdi;
        logic [STAT_W-1:0] status;
    } st_t;

    st_t               d, q;
    logic              fall_now, rise_now;
    logic              scr_tms, scr_tdi, scr_last, scr_cap;
    logic [STAT_W-1:0] cap_word;
    logic              accept;

    csr_tck_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.busy),
        .fall_now (fall_now),
        .rise_now (rise_now),
        .tck      (tck)
    );

    csr_script #(
        .IR_LEN   (IR_LEN),
        .IN_CODE  (IN_CODE),
        .OUT_CODE (OUT_CODE),
        .STAT_W   (STAT_W),
        .BIT_W    (BIT_W)
    ) u_script (
        .seg     (q.seg),
        .bitn    (q.bitn),
        .pass    (q.pass),
        .tms     (scr_tms),
        .tdi     (scr_tdi),
        .last    (scr_last),
        .capture (scr_cap)
    );

    assign accept = start && !q.busy;

    csr_shift_cap #(.W(STAT_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .shift (q.busy && rise_now && scr_cap),
        .din   (tdo),
        .word  (cap_word)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (accept) begin
            d.busy = 1'b1;
            d.seg  = S_RST_A;
            d.bitn = '0;
            d.pass = 1'b0;
        end else if (q.busy) begin
            if (fall_now) begin
                if (q.seg == S_DONE) begin
                    d.busy   = 1'b0;
                    d.done   = 1'b1;
                    d.status = cap_word;
                    d.tdi    = 1'b0;
                    d.seg    = S_IDLE;
                end else begin
                    d.tms = scr_tms;
                    d.tdi = scr_tdi;
                end
            end
            if (rise_now) begin
                if (scr_last) begin
                    d.bitn = '0;
                    case (q.seg)
                        S_RST_A: d.seg = S_RTI;
                        S_RTI:   d.seg = S_SELIR;
                        S_SELIR: d.seg = S_CAPIR;
                        S_CAPIR: d.seg = S_SHIR;
                        S_SHIR:  d.seg = S_TODR;
                        S_TODR:  d.seg = q.pass ? S_RDDR : S_WRDR;
                        S_WRDR: begin
                            d.seg  = S_TOIR;
                            d.pass = 1'b1;
                        end
                        S_TOIR:  d.seg = S_CAPIR;
                        S_RDDR:  d.seg = S_RST_B;
                        S_RST_B: d.seg = S_DONE;
                        default: d.seg = S_DONE;
                    endcase
                end else begin
                    d.bitn = q.bitn + {{(BIT_W-1){1'b0}}, 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.seg    <= S_IDLE;
            q.bitn   <= '0;
            q.pass   <= 1'b0;
            q.busy   <= 1'b0;
            q.done   <= 1'b0;
            q.tms    <= 1'b1;
            q.tdi    <= 1'b0;
            q.status <= '0;
        end else begin
            q <= d;
        end
    end

    assign tms    = q.tms;
    assign tdi    = q.tdi;
    assign busy   = q.busy;
    assign done   = q.done;
    assign status = q.status;

endmodule

// File: rtl/cfg_stat_reader_chk.sv
module cfg_stat_reader_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              tck,
    input logic              tms,
    input logic              tdi,
    input logic              busy,
    input logic              done,
    input logic [STAT_W-1:0] status
);
    // R2: no TCK activity while idle
    p_tck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    // R2: TMS and TDI hold while TCK stays high
    p_pins_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

    // R3: target left in reset between runs
    p_tms_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tms);

    // R10: TDI low when idle
    p_tdi_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tdi);

    // R7: status moves only with done
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> done);

    // R9: single-cycle done at end of busy
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R11: idle start is taken on the next edge
    p_start_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind cfg_stat_reader cfg_stat_reader_chk #(.STAT_W(STAT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tck    (tck),
    .tms    (tms),
    .tdi    (tdi),
    .busy   (busy),
    .done   (done),
    .status (status)
);

// File: tb/cfg_stat_reader_bench.sv
`timescale 1ns/1ps
module cfg_stat_reader_bench;
    localparam int          DIV  = 4;
    localparam logic [9:0]  C_IN  = 10'h3C5;
    localparam logic [9:0]  C_OUT = 10'h3C4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tdo = 1'b0;
    logic        tck, tms, tdi, busy, done;
    logic [31:0] status;

    always #2.5 clk = ~clk;

    cfg_stat_reader #(.CLK_DIV(DIV), .IR_LEN(10), .IN_CODE(C_IN),
                      .OUT_CODE(C_OUT), .STAT_W(32)) u_cfg_stat_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .tdo(tdo), .tck(tck),
        .tms(tms), .tdi(tdi), .busy(busy), .done(done), .status(status));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected per-TCK-period script
    bit    q_tms[$];
    bit    q_tdi[$];
    string q_tag[$];

    task automatic add(input bit m, input bit i, input string tag);
        q_tms.push_back(m); q_tdi.push_back(i); q_tag.push_back(tag);
    endtask

    function automatic logic [31:0] word_of(input int w);
        case (w)
            0: return 32'hAA995566;
            1: return 32'h20000000;
            2: return 32'h2800E001;
            default: return 32'h20000000;
        endcase
    endfunction

    task automatic build_script();
        for (int k = 0; k < 5; k++) add(1, 0, "R3 R10");
        add(0, 0, "R3 R10");
        for (int k = 0; k < 2; k++) add(1, 0, "R3 R10");
        for (int k = 0; k < 2; k++) add(0, 0, "R3 R10");
        for (int k = 0; k < 10; k++) add(k == 9, C_IN[k], "R4");
        add(1, 0, "R3 R10"); add(1, 0, "R3 R10"); add(0, 0, "R3 R10"); add(0, 0, "R3 R10");
        for (int w = 0; w < 5; w++)
            for (int b = 31; b >= 0; b--) add((w == 4) && (b == 0), word_of(w)[b], "R5");
        for (int k = 0; k < 3; k++) add(1, 0, "R3 R10");
        for (int k = 0; k < 2; k++) add(0, 0, "R3 R10");
        for (int k = 0; k < 10; k++) add(k == 9, C_OUT[k], "R4");
        add(1, 0, "R3 R10"); add(1, 0, "R3 R10"); add(0, 0, "R3 R10"); add(0, 0, "R3 R10");
        for (int k = 0; k < 32; k++) add(k == 31, 0, "R6 R10");
        for (int k = 0; k < 5; k++) add(1, 0, "R3 R10");
    endtask

    always @(posedge tck) begin
        if (q_tms.size() == 0) begin
            chk(0, "R3", "TCK edge beyond script", 1, 0);
        end else begin
            chk(tms === q_tms[0], q_tag[0], "tms per period", 64'(tms), 64'(q_tms[0]));
            chk(tdi === q_tdi[0], q_tag[0], "tdi per period", 64'(tdi), 64'(q_tdi[0]));
            void'(q_tms.pop_front()); void'(q_tdi.pop_front()); void'(q_tag.pop_front());
        end
    end

    // behavioural target TAP
    int          tap_st = 0;
    logic [9:0]  ir_sh = '0;
    logic [9:0]  cur_ir = '0;
    logic [31:0] tap_stat = '0;
    int          rd_idx = 0;
    logic [9:0]  ir_log[$];
    bit          dr_log[$];

    function automatic int tap_next(input int s, input bit m);
        case (s)
            0: return m ? 0 : 1;    1: return m ? 2 : 1;
            2: return m ? 9 : 3;    3: return m ? 5 : 4;
            4: return m ? 5 : 4;    5: return m ? 8 : 6;
            6: return m ? 7 : 6;    7: return m ? 8 : 4;
            8: return m ? 2 : 1;    9: return m ? 0 : 10;
            10: return m ? 12 : 11; 11: return m ? 12 : 11;
            12: return m ? 15 : 13; 13: return m ? 14 : 13;
            14: return m ? 15 : 11; default: return m ? 2 : 1;
        endcase
    endfunction

    always @(posedge tck) begin
        if (tap_st == 11) ir_sh = {tdi, ir_sh[9:1]};
        if (tap_st == 4 && cur_ir == C_IN) dr_log.push_back(tdi);
        if (tap_st == 15) begin cur_ir = ir_sh; ir_log.push_back(ir_sh); end
        if (tap_st == 3) rd_idx = 0;
        tap_st = tap_next(tap_st, tms);
    end

    always @(negedge tck) begin
        if (tap_st == 4) begin
            tdo = (cur_ir == C_OUT) ? tap_stat[rd_idx % 32] : 1'b0;
            rd_idx++;
        end
    end

    // TCK shape and pin-change timing (R2)
    logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0;
    int   run_len = 0;
    bit   seen_fall = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tck !== p_tck) begin
                if (p_tck) begin
                    chk(run_len == DIV - DIV/2, "R2", "tck high length", 64'(run_len), 64'(DIV - DIV/2));
                    seen_fall = 1;
                end else if (seen_fall) begin
                    chk(run_len == DIV/2, "R2", "tck low length", 64'(run_len), 64'(DIV/2));
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            if (tms !== p_tms || tdi !== p_tdi)
                chk(p_tck && !tck, "R2", "pin change off falling TCK", 64'(tck), 0);
            if (!busy) seen_fall = 0;
            if (!busy) chk(tck === 1'b0, "R2", "tck idle", 64'(tck), 0);
        end
        p_tck = tck; p_tms = tms; p_tdi = tdi;
    end

    task automatic prepare(input logic [31:0] v);
        tap_stat = v;
        ir_log.delete();
        dr_log.delete();
        build_script();
    endtask

    task automatic wait_run(input logic [31:0] v, input logic [31:0] prev_v,
                            input bit mid, input bit chain, input logic [31:0] nv);
        int  cnt = 0;
        int  ndone = 0;
        bit  seen = 0;
        while (!seen) begin
            @(negedge clk);
            start = mid && (cnt >= 100) && (cnt < 103);
            if (busy) cnt++;
            if (cnt == 500)
                chk(status === prev_v, "R7", "status held during run", 64'(status), 64'(prev_v));
            if (done) begin seen = 1; ndone++; end
        end
        chk(cnt == 1 + 240*DIV, "R8", "busy length", 64'(cnt), 64'(1 + 240*DIV));
        if (mid) chk(cnt == 1 + 240*DIV, "R11", "busy start ignored", 64'(cnt), 64'(1 + 240*DIV));
        chk(status === v, "R6", "captured status", 64'(status), 64'(v));
        chk(ir_log.size() == 2, "R4", "instruction count", 64'(ir_log.size()), 2);
        if (ir_log.size() == 2) begin
            chk(ir_log[0] === C_IN, "R4", "first instruction", 64'(ir_log[0]), 64'(C_IN));
            chk(ir_log[1] === C_OUT, "R4", "second instruction", 64'(ir_log[1]), 64'(C_OUT));
        end
        chk(dr_log.size() == 160, "R5", "packet bits", 64'(dr_log.size()), 160);
        if (dr_log.size() == 160)
            for (int w = 0; w < 5; w++) begin
                logic [31:0] got = '0;
                for (int b = 0; b < 32; b++) got[31-b] = dr_log[w*32 + b];
                chk(got === word_of(w), "R5", "packet word", 64'(got), 64'(word_of(w)));
            end
        chk(tap_st == 0, "R3", "target in reset", 64'(tap_st), 0);
        chk(q_tms.size() == 0, "R3", "script periods left", 64'(q_tms.size()), 0);
        if (chain) begin
            prepare(nv);
            start = 1'b1;
        end else begin
            @(negedge clk);
            chk(done === 1'b0 && busy === 1'b0, "R9", "done single cycle", 64'({done, busy}), 0);
            repeat (20) @(negedge clk);
            chk(status === v && ndone == 1, "R7", "status held idle", 64'(status), 64'(v));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tck === 0 && tms === 1 && tdi === 0, "R1", "reset pins", 64'({tck, tms, tdi}), 64'(3'b010));
        chk(busy === 0 && done === 0 && status === 0, "R1", "reset flags", 64'({busy, done, status}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        prepare(32'hA5C3_0F96);
        start = 1'b1;
        wait_run(32'hA5C3_0F96, 32'h0, 0, 0, 0);

        prepare(32'h8000_0001);
        @(negedge clk); start = 1'b1;
        wait_run(32'h8000_0001, 32'hA5C3_0F96, 1, 1, 32'hDEAD_BEEF);
        wait_run(32'hDEAD_BEEF, 32'h8000_0001, 0, 0, 0);

        prepare(32'h0000_0000);
        @(negedge clk); start = 1'b1;
        wait_run(32'h0000_0000, 32'hDEAD_BEEF, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule